// File: doc/BRIEF.md
# BCD Time-of-Day Clock Core

This core keeps the time of day for a display. A clock-enable that pulses at a 32.768 kHz rate arrives on `ref_en`. A binary prescaler counts 2^15 of these pulses and then emits a one-cycle `tick_1hz` pulse. The time is held as six BCD digits: seconds, minutes and hours, each split into a tens digit and a units digit. Every register runs on the single system clock.

The seconds and minutes stages each count modulo 60. Each is built from a units digit that counts modulo 10. When the units digit wraps, it enables a tens digit that counts modulo 6. The carry out of one stage enables the stage above it, so the whole chain moves on one clock edge.

The hours stage runs in one of two formats, chosen by a parameter:

- **24-hour format:** the hours run 00 to 23.
- **12-hour format:** the hours run 01 to 12 and step from 12 to 01.

The hours stage chooses one of three moves on each step:

- `HR_STEP` increments the units digit.
- `HR_UNITS_WRAP` clears the units digit and increments the tens digit.
- `HR_DAY_WRAP` returns to the first hour of the format.

The prescaler has two variants. A zero-width prescaler registers `ref_en` directly. Any other width uses a binary counter.

Top module: `tod_clock_core`

## Requirements
- R1: While `rst_n` is low, the prescaler is cleared and `tick_1hz` is 0. The digits read 00:00:00 in 24-hour format and 12:00:00 in 12-hour format.
- R2: `tick_1hz` is high for exactly one cycle, one cycle after every 2^PRESCALE_BITS-th cycle with `ref_en` high. Cycles with `ref_en` low do not count.
- R3: The seconds units digit advances by one in the cycle after each tick and wraps from 9 to 0.
- R4: The seconds tens digit advances only when the seconds units digit wraps, and it wraps from 5 to 0.
- R5: The minutes units digit advances only when the seconds go from 59 to 00, and it wraps from 9 to 0.
- R6: The minutes tens digit advances only when the minutes units digit wraps, and it wraps from 5 to 0.
- R7: With HOUR_12 = 0, the hours advance when the time goes from MM:SS 59:59 to 00:00 and run 00 to 23. The time 23:59:59 is followed by 00:00:00.
- R8: With HOUR_12 = 1, the hours run 01 to 12. The hour 12 is followed by 01, and 11:59:59 is followed by 12:00:00.
- R9: Every digit is a 4-bit BCD value no greater than 9. Seconds tens and minutes tens never exceed 5, and hours tens never exceeds 2.
- R10: In any cycle after a cycle with `tick_1hz` low, all six digits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | 32.768 kHz reference clock-enable |
| tick_1hz | output | 1 | One-cycle pulse once per second |
| sec_ones | output | 4 | Seconds units (BCD) |
| sec_tens | output | 4 | Seconds tens (BCD) |
| min_ones | output | 4 | Minutes units (BCD) |
| min_tens | output | 4 | Minutes tens (BCD) |
| hr_ones | output | 4 | Hours units (BCD) |
| hr_tens | output | 4 | Hours tens (BCD) |

## Verification
The assertions check the following on every cycle:
- the digit ranges and the hour range for the selected format;
- that a tick only follows a cycle with `ref_en` high;
- that the digits hold between ticks;
- the single-cycle seconds-units step and wrap;
- that the minutes hold unless the seconds are at 59.

Only the bench scenarios can show that the prescaler counts exactly 2^PRESCALE_BITS enables, with enable gaps inserted at random. The same is true of the full rollovers at 23:59:59 and 11:59:59 and of the return to the initial time on a reset in mid-count. The bench runs a whole 24-hour day and two 12-hour half-days on instances with a short prescaler.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    // Moves the hours stage can take on a step.
    typedef enum logic [1:0] {
        HR_STEP       = 2'd0,
        HR_UNITS_WRAP = 2'd1,
        HR_DAY_WRAP   = 2'd2
    } hr_move_e;

    // Minute/second chain: even stages are units (mod 10), odd stages are tens (mod 6).
    function automatic int unsigned stage_modulus(input int unsigned idx);
        return (idx % 2 == 0) ? 10 : 6;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int unsigned PRESCALE_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    output logic tick
);

    logic tick_q;

    generate
        if (PRESCALE_BITS == 0) begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tick_q <= 1'b0;
                else        tick_q <= ref_en;
            end
        end else begin : g_count
            logic [PRESCALE_BITS-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= ref_en && (&cnt_q);
                    if (ref_en) cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    assign tick = tick_q;

endmodule

// File: rtl/tod_bcd_digit.sv
module tod_bcd_digit
    import tod_pkg::*;
#(
    parameter int unsigned MODULUS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output bcd_t value,
    output logic carry
);

    localparam bcd_t LAST = bcd_t'(MODULUS - 1);

    bcd_t value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (step) begin
            value_q <= (value_q == LAST) ? bcd_t'(0) : bcd_t'(value_q + 4'd1);
        end
    end

    assign value = value_q;
    assign carry = step && (value_q == LAST);

endmodule

// File: rtl/tod_hour_stage.sv
module tod_hour_stage
    import tod_pkg::*;
#(
    parameter bit HOUR_12 = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output bcd_t tens,
    output bcd_t ones
);

    localparam bcd_t RST_TENS  = HOUR_12 ? bcd_t'(1) : bcd_t'(0);
    localparam bcd_t RST_ONES  = HOUR_12 ? bcd_t'(2) : bcd_t'(0);
    localparam bcd_t END_TENS  = HOUR_12 ? bcd_t'(1) : bcd_t'(2);
    localparam bcd_t END_ONES  = HOUR_12 ? bcd_t'(2) : bcd_t'(3);
    localparam bcd_t WRAP_ONES = HOUR_12 ? bcd_t'(1) : bcd_t'(0);

    bcd_t     tens_q, ones_q;
    bcd_t     tens_d, ones_d;
    hr_move_e move;

    always_comb begin
        if (tens_q == END_TENS && ones_q == END_ONES) move = HR_DAY_WRAP;
        else if (ones_q == bcd_t'(9))                 move = HR_UNITS_WRAP;
        else                                          move = HR_STEP;
    end

    always_comb begin
        tens_d = tens_q;
        ones_d = ones_q;
        unique case (move)
            HR_STEP: begin
                ones_d = bcd_t'(ones_q + 4'd1);
            end
            HR_UNITS_WRAP: begin
                ones_d = '0;
                tens_d = bcd_t'(tens_q + 4'd1);
            end
            HR_DAY_WRAP: begin
                tens_d = '0;
                ones_d = WRAP_ONES;
            end
            default: begin
                tens_d = tens_q;
                ones_d = ones_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens_q <= RST_TENS;
            ones_q <= RST_ONES;
        end else if (step) begin
            tens_q <= tens_d;
            ones_q <= ones_d;
        end
    end

    assign tens = tens_q;
    assign ones = ones_q;

endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
    import tod_pkg::*;
#(
    parameter int unsigned PRESCALE_BITS = 15,
    parameter bit          HOUR_12       = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    output logic       tick_1hz,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] hr_tens
);

    localparam int unsigned N_STAGES = 4;

    logic                tick;
    logic [N_STAGES:0]   chain_en;
    bcd_t                digit [N_STAGES];

    tod_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .tick   (tick)
    );

    assign chain_en[0] = tick;

    generate
        for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
            tod_bcd_digit #(.MODULUS(stage_modulus(g))) u_digit (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (chain_en[g]),
                .value (digit[g]),
                .carry (chain_en[g+1])
            );
        end
    endgenerate

    tod_hour_stage #(.HOUR_12(HOUR_12)) u_hours (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (chain_en[N_STAGES]),
        .tens  (hr_tens),
        .ones  (hr_ones)
    );

    assign tick_1hz = tick;
    assign sec_ones = digit[0];
    assign sec_tens = digit[1];
    assign min_ones = digit[2];
    assign min_tens = digit[3];

endmodule

// File: rtl/tod_clock_core_chk.sv
module tod_clock_core_chk #(
    parameter bit HOUR_12 = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_en,
    input logic       tick_1hz,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] hr_tens
);

    logic [5:0] hr_val;
    logic       hr_ok;

    always_comb begin
        hr_val = {2'b00, hr_tens} * 6'd10 + {2'b00, hr_ones};
        hr_ok  = HOUR_12 ? (hr_val >= 6'd1 && hr_val <= 6'd12) : (hr_val <= 6'd23);
    end

    p_tick_needs_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> $past(ref_en));

    p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_ones <= 4'd9 && sec_tens <= 4'd5 && min_ones <= 4'd9 &&
        min_tens <= 4'd5 && hr_ones <= 4'd9 && hr_tens <= 4'd2);

    p_hour_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !HOUR_12 |-> hr_ok);

    p_hour_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        HOUR_12 |-> hr_ok);

    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |=> $stable({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens}));

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && sec_ones != 4'd9) |=> sec_ones == $past(sec_ones) + 4'd1);

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && sec_ones == 4'd9) |=> sec_ones == 4'd0);

    p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_tens == 4'd5 && sec_ones == 4'd9) |=> $stable(min_ones));

endmodule

bind tod_clock_core tod_clock_core_chk #(.HOUR_12(HOUR_12)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .tick_1hz (tick_1hz),
    .sec_ones (sec_ones),
    .sec_tens (sec_tens),
    .min_ones (min_ones),
    .min_tens (min_tens),
    .hr_ones  (hr_ones),
    .hr_tens  (hr_tens)
);

// File: tb/test_tod_clock_core.sv
`timescale 1ns/1ps
module test_tod_clock_core;

    localparam int NI = 4;
    localparam int PB [NI] = '{15, 3, 0, 0};
    localparam bit H12[NI] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_en = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] d [NI][6];   // sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens
    logic       tk[NI];

    tod_clock_core i_tod_clock_core (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tick_1hz(tk[0]),
        .sec_ones(d[0][0]), .sec_tens(d[0][1]), .min_ones(d[0][2]),
        .min_tens(d[0][3]), .hr_ones(d[0][4]), .hr_tens(d[0][5]));

    tod_clock_core #(.PRESCALE_BITS(3), .HOUR_12(1'b1)) i_tod_clock_core_p3 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tick_1hz(tk[1]),
        .sec_ones(d[1][0]), .sec_tens(d[1][1]), .min_ones(d[1][2]),
        .min_tens(d[1][3]), .hr_ones(d[1][4]), .hr_tens(d[1][5]));

    tod_clock_core #(.PRESCALE_BITS(0), .HOUR_12(1'b0)) i_tod_clock_core_f24 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tick_1hz(tk[2]),
        .sec_ones(d[2][0]), .sec_tens(d[2][1]), .min_ones(d[2][2]),
        .min_tens(d[2][3]), .hr_ones(d[2][4]), .hr_tens(d[2][5]));

    tod_clock_core #(.PRESCALE_BITS(0), .HOUR_12(1'b1)) i_tod_clock_core_f12 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .tick_1hz(tk[3]),
        .sec_ones(d[3][0]), .sec_tens(d[3][1]), .min_ones(d[3][2]),
        .min_tens(d[3][3]), .hr_ones(d[3][4]), .hr_tens(d[3][5]));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model: prescale count, seconds of day, pending tick.
    int pre[NI];
    int sec[NI];
    bit etk[NI];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NI; i++) begin
                pre[i] = 0; sec[i] = 0; etk[i] = 1'b0;
            end
        end else begin
            for (int i = 0; i < NI; i++) begin
                int lim;
                lim = (1 << PB[i]) - 1;
                if (etk[i]) sec[i] = (sec[i] + 1) % (H12[i] ? 43200 : 86400);
                etk[i] = ref_en && (pre[i] == lim);
                if (ref_en) pre[i] = (pre[i] == lim) ? 0 : pre[i] + 1;
            end
        end
    end

    // Expected digits {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones}.
    function automatic logic [23:0] exp_time(int s, bit h12);
        int hh, mm, ss;
        hh = s / 3600;
        mm = (s / 60) % 60;
        ss = s % 60;
        if (h12) hh = (hh % 12 == 0) ? 12 : hh % 12;
        return {4'(hh / 10), 4'(hh % 10), 4'(mm / 10), 4'(mm % 10), 4'(ss / 10), 4'(ss % 10)};
    endfunction

    task automatic chk(string tag, int i, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s inst%0d t=%0t actual=%0d expected=%0d", tag, i, $time, got, exp);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NI; i++) begin
            logic [23:0] e;
            e = exp_time(sec[i], H12[i]);
            chk("R2 tick", i, int'(tk[i]), int'(etk[i]));
            // R10: digits hold between ticks, covered by matching the model every cycle
            chk("R3 sec_ones", i, d[i][0], e[3:0]);
            chk("R4 sec_tens", i, d[i][1], e[7:4]);
            chk("R5 min_ones", i, d[i][2], e[11:8]);
            chk("R6 min_tens", i, d[i][3], e[15:12]);
            chk(H12[i] ? "R8 hours" : "R7 hours", i, {d[i][5], d[i][4]}, e[23:16]);
            chk("R9 bcd range", i,
                int'(d[i][0] <= 9 && d[i][1] <= 5 && d[i][2] <= 9 &&
                     d[i][3] <= 5 && d[i][4] <= 9 && d[i][5] <= 2), 1);
        end
    endtask

    task automatic check_reset();
        for (int i = 0; i < NI; i++) begin
            chk("R1 reset tick", i, int'(tk[i]), 0);
            chk("R1 reset time", i,
                {d[i][5], d[i][4], d[i][3], d[i][2], d[i][1], d[i][0]},
                H12[i] ? 24'h120000 : 24'h000000);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        // Random enable gaps: R2 prescaler counting, R10 hold between ticks.
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            check_all();
            ref_en = ($urandom_range(0, 3) != 0);
        end
        // Reset in the middle of a count.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            check_all();
            ref_en = $urandom_range(0, 1);
        end
        // Continuous enable: full day rollover (R7) and 12-hour wraps (R8).
        ref_en = 1'b1;
        for (int c = 0; c < 90000; c++) begin
            @(negedge clk);
            check_all();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule